// File: doc/BRIEF.md
# Stereo Soft Mute Attenuator

This block scales a stereo stream of 24-bit two's-complement samples by a gain that moves in a straight line, one step per frame. A frame is one stereo sample pair, marked by a single-cycle valid strobe. While the mute request is high, each frame lowers the gain one step until the output is exact silence. When the request drops, the gain climbs back to unity at the same rate. If the request drops part-way down, the ramp turns round from the level it had reached. Samples keep flowing the whole time.

The gain is held as an attenuation count from 0 (unity) to 4096 (silence). The step size per frame comes from a 2-bit speed input, so a full ramp takes 1024, 2048 or 4096 frames. Each scaled product is rounded toward zero and clamped to the 24-bit range. The result is registered and presented one cycle after the input strobe.

Top module: `soft_mute_attenuator`

## Requirements
- R1: After reset, out_valid is low, both outputs are zero, and the attenuation count is 0, so the first frame after reset passes through at unity.
- R2: While the attenuation count is 0, every sample (including 0x7FFFFF, 0x800000 and -1) appears unchanged at the output.
- R3: With mute_req high and speed_mode 2'b00 (normal), the count rises by 4 per frame. The 1025th frame after the start of the ramp and every later frame output exactly zero.
- R4: speed_mode 2'b01 (double) steps by 2 per frame, a 2048-frame ramp. speed_mode 2'b10 and 2'b11 (quad) step by 1 per frame, a 4096-frame ramp.
- R5: With mute_req low, the count falls by the same per-frame step and stops at 0. The return to unity takes as many frames as the ramp down.
- R6: If mute_req falls before silence is reached, the count reverses from its current value without jumping. After as many unmuted frames as muted ones, the output is back at unity.
- R7: Each output equals trunc_toward_zero(sample × (4096 − count) / 4096), clamped to [0x800000, 0x7FFFFF]. The count used is the one in force before that frame's update.
- R8: out_valid is high exactly in the cycle after an in_valid cycle. The outputs and the count hold their values in cycles without a strobe.
- R9: mute_req passes through a two-flop synchroniser. A change that is stable for at least three cycles before a strobe takes effect on that strobe's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Frame strobe: one stereo pair per high cycle |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| mute_req | input | 1 | Asynchronous mute request, high = ramp to silence |
| speed_mode | input | 2 | 00 normal, 01 double, 10/11 quad |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_left | output | 24 | Attenuated left sample |
| out_right | output | 24 | Attenuated right sample |

## Verification
The unity path is driven with a table of extreme and ordinary pairs: full scale of both signs, zero, -1 and mixed values. This shows that a count of zero adds no rounding or clamping error. Full ramps are run down and up in each speed mode. Every frame is compared with an independent model, and the samples mix full scale with small negative values, so rounding toward zero can be told apart from flooring and a wrong step size shows as a wrong frame count. A mute released part-way and a reset during silence check that the ramp reverses from its current level and that reset returns the gain to unity.

// File: rtl/smute_pkg.sv
package smute_pkg;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_QUAD_B = 2'b11
    } speed_e;

    // log2 of the per-frame attenuation step for each speed
    function automatic int unsigned step_shift(input logic [1:0] spd);
        case (speed_e'(spd))
            SPD_NORMAL: step_shift = 2;
            SPD_DOUBLE: step_shift = 1;
            default:    step_shift = 0;
        endcase
    endfunction

endpackage

// File: rtl/smute_sync.sv
module smute_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/smute_ramp.sv
module smute_ramp #(
    parameter int GAIN_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_stb,
    input  logic            mute,
    input  logic [1:0]      speed,
    output logic [GAIN_W:0] gain
);
    localparam int AW = GAIN_W + 1;
    localparam logic [AW-1:0] FULL = {1'b1, {GAIN_W{1'b0}}};

    typedef struct packed {
        logic [AW-1:0] att;
    } ramp_t;

    ramp_t         st_d, st_q;
    logic [AW-1:0] step;

    always_comb begin
        step = AW'(1) << smute_pkg::step_shift(speed);
        st_d = st_q;
        if (frame_stb) begin
            if (mute) begin
                if (st_q.att >= FULL - step) st_d.att = FULL;
                else                         st_d.att = st_q.att + step;
            end else begin
                if (st_q.att <= step) st_d.att = '0;
                else                  st_d.att = st_q.att - step;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gain = FULL - st_q.att;

    a_r3_att_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.att <= FULL);
    a_r8_att_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(st_q.att));
    a_r5_no_rise_unmuted: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !mute) |=> st_q.att <= $past(st_q.att));
    a_r3_no_fall_muted: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && mute) |=> st_q.att >= $past(st_q.att));
    a_r6_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> ((st_q.att >= $past(st_q.att)) ? (st_q.att - $past(st_q.att))
                                                     : ($past(st_q.att) - st_q.att)) <= AW'(4));
endmodule

// File: rtl/smute_scale.sv
module smute_scale #(
    parameter int SAMPLE_W = 24,
    parameter int GAIN_W   = 12
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [GAIN_W:0]     gain,
    output logic [SAMPLE_W-1:0] scaled
);
    localparam int PW = SAMPLE_W + GAIN_W + 2;
    localparam logic signed [PW-1:0] MAXV = PW'((longint'(1) << (SAMPLE_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
    localparam logic signed [PW-1:0] BIAS = PW'((longint'(1) << GAIN_W) - 1);

    logic signed [PW-1:0] s_ext, g_ext, prod, biased, shifted;

    always_comb begin
        s_ext   = PW'($signed(sample));
        g_ext   = PW'($signed({1'b0, gain}));
        prod    = s_ext * g_ext;
        // negative products get a bias so the arithmetic shift truncates toward zero
        biased  = prod[PW-1] ? prod + BIAS : prod;
        shifted = biased >>> GAIN_W;
        if (shifted > MAXV)      scaled = MAXV[SAMPLE_W-1:0];
        else if (shifted < MINV) scaled = MINV[SAMPLE_W-1:0];
        else                     scaled = shifted[SAMPLE_W-1:0];
    end
endmodule

// File: rtl/soft_mute_attenuator.sv
module soft_mute_attenuator #(
    parameter int SAMPLE_W    = 24,
    parameter int GAIN_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                mute_req,
    input  logic [1:0]          speed_mode,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right
);
    localparam int NCH = 2;
    localparam logic [GAIN_W:0] UNITY = {1'b1, {GAIN_W{1'b0}}};

    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } out_t;

    logic                mute_s;
    logic [GAIN_W:0]     gain;
    logic [SAMPLE_W-1:0] ch_in  [NCH];
    logic [SAMPLE_W-1:0] ch_out [NCH];
    out_t                st_d, st_q;

    smute_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(mute_req), .sync_out(mute_s)
    );

    smute_ramp #(.GAIN_W(GAIN_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .frame_stb(in_valid),
        .mute(mute_s), .speed(speed_mode), .gain(gain)
    );

    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        smute_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_scale (
            .sample(ch_in[c]), .gain(gain), .scaled(ch_out[c])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.left  = ch_out[0];
            st_d.right = ch_out[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_left  = st_q.left;
    assign out_right = st_q.right;

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));
    a_r3_silence_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && gain == '0) |=> (out_left == '0 && out_right == '0));
    a_r2_unity_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && gain == UNITY) |=> (out_left == $past(in_left) && out_right == $past(in_right)));
endmodule

// File: tb/test_soft_mute_attenuator.sv
module test_soft_mute_attenuator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;
    logic        mute_req = 1'b0;
    logic [1:0]  speed_mode = 2'b00;
    logic        out_valid;
    logic [23:0] out_left, out_right;

    int n_vec = 0, n_err = 0;
    int att_m = 0;
    bit mute_m = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    soft_mute_attenuator i_soft_mute_attenuator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .mute_req(mute_req), .speed_mode(speed_mode),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    localparam logic [47:0] UNITY_VEC [8] = '{
        {24'h7FFFFF, 24'h800000}, {24'h000000, 24'h000000},
        {24'hFFFFFF, 24'h000001}, {24'h123456, 24'hEDCBA9},
        {24'h800000, 24'h7FFFFF}, {24'h400000, 24'hC00000},
        {24'h000FFF, 24'hFFF001}, {24'h5A5A5A, 24'hA5A5A5}
    };

    function automatic logic [23:0] exp_scale(input logic [23:0] s, input int att);
        longint sv, q;
        sv = longint'($signed(s));
        q  = (sv * longint'(4096 - att)) / 4096;
        if (q > 8388607)  q = 8388607;
        if (q < -8388608) q = -8388608;
        return q[23:0];
    endfunction

    function automatic int step_m(input logic [1:0] m);
        return (m == 2'b00) ? 4 : (m == 2'b01) ? 2 : 1;
    endfunction

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one frame: strobe, check result, check idle hold, update the model
    task automatic frame(input string tag, input logic [23:0] l, input logic [23:0] r);
        logic [23:0] el, er;
        el = exp_scale(l, att_m);
        er = exp_scale(r, att_m);
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, "/R8 valid"}, {23'd0, out_valid}, 24'd1);
        chk({tag, "/R7 left"}, out_left, el);
        chk({tag, "/R7 right"}, out_right, er);
        in_left = ~l; in_right = ~r;
        @(negedge clk);
        chk({tag, "/R8 idle valid"}, {23'd0, out_valid}, 24'd0);
        chk({tag, "/R8 hold"}, out_left, el);
        if (mute_m) att_m = (att_m + step_m(speed_mode) > 4096) ? 4096 : att_m + step_m(speed_mode);
        else        att_m = (att_m - step_m(speed_mode) < 0) ? 0 : att_m - step_m(speed_mode);
    endtask

    task automatic set_mute(input bit m);
        @(negedge clk);
        mute_req = m; mute_m = m;
        repeat (3) @(negedge clk);  // R9: settle through the synchroniser
    endtask

    task automatic run(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            logic [23:0] l, r;
            l = (k % 3 == 0) ? 24'h7FFFFF : 24'(k * 40961);
            r = (k % 4 == 1) ? 24'hFFFFF5 : 24'h800000;
            frame(tag, l, r);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", {23'd0, out_valid}, 24'd0);
        chk("R1 left", out_left, 24'd0);
        chk("R1 right", out_right, 24'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: unity vectors
        for (int i = 0; i < 8; i++) frame("R2", UNITY_VEC[i][47:24], UNITY_VEC[i][23:0]);

        // R3/R5: normal mode full ramp down and up
        speed_mode = 2'b00;
        set_mute(1'b1);
        run("R3 down", 1024);
        frame("R3 silent", 24'h7FFFFF, 24'h800000);
        chk("R3 zero at end", out_left, 24'd0);
        set_mute(1'b0);
        run("R5 up", 1024);
        frame("R5 unity", 24'h7FFFFF, 24'h800000);
        chk("R5 back to unity", out_left, 24'h7FFFFF);

        // R6: release mid-ramp
        set_mute(1'b1);
        run("R6 down", 300);
        set_mute(1'b0);
        run("R6 up", 300);
        frame("R6 unity", 24'h7FFFFF, 24'h800000);
        chk("R6 unity after reverse", out_right, 24'h800000);

        // R4: double speed
        speed_mode = 2'b01;
        set_mute(1'b1);
        run("R4 dbl down", 2047);
        frame("R4 dbl last", 24'h7FFFFF, 24'h800000);
        chk("R4 dbl not yet zero", {23'd0, out_left != 0}, 24'd1);
        frame("R4 dbl silent", 24'h7FFFFF, 24'h800000);
        chk("R4 dbl zero", out_left, 24'd0);
        set_mute(1'b0);
        run("R4 dbl up", 2048);

        // R4: quad speed and alternate code
        speed_mode = 2'b10;
        set_mute(1'b1);
        run("R4 quad down", 4096);
        frame("R4 quad silent", 24'h7FFFFF, 24'h800000);
        chk("R4 quad zero", out_right, 24'd0);
        set_mute(1'b0);
        speed_mode = 2'b11;
        run("R4 code11 up", 20);

        // R1: reset mid-attenuation returns to unity
        rst_n = 1'b0; att_m = 0;
        @(negedge clk);
        chk("R1 reset left", out_left, 24'd0);
        chk("R1 reset valid", {23'd0, out_valid}, 24'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        frame("R1 unity after reset", 24'h654321, 24'h9ABCDE);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule